// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single register-level requests into correctly timed bus cycles on the pins of a NAND flash device. There are four kinds of request: a command byte, an address byte, a data write and a data read. The block runs each accepted request through three timed phases: setup, active and hold. During the whole cycle it holds the command-latch or address-latch enable. During the active phase it pulses the write strobe or the read strobe low. The length of each phase comes from its own programmable field, counted in system clocks.

A configuration write loads, in one cycle, the three timing fields, the bus-width bit, the controller-enable bit and the chip-enable control bit. A request takes a snapshot of the timing and width values when it is accepted, so a later configuration write does not disturb a cycle that is already under way. Read data is captured at the rising edge of the read strobe. The block returns that data together with a one-cycle done pulse. Ready/busy polling and ECC belong to the surrounding logic.

Top module: `nand_cycle_seq`

## Requirements
- R1: Request kinds are encoded on `req_kind` as 0 command, 1 address, 2 data write and 3 data read. A request is accepted on a clock edge where `req_valid` is 1, the controller is enabled and `busy` is 0. `busy` is 1 from the cycle after acceptance until the hold phase ends. A request presented while `busy` is 1 is ignored.
- R2: The setup phase lasts exactly `setup` cycles, for setup values 0 to 3. During it the latch enable is asserted and both strobes are high. A setup value of 0 starts the active phase directly after acceptance.
- R3: The active phase lasts `active`+1 cycles. `nand_we_n` is low during it for command, address and write requests. `nand_re_n` is low during it for read requests. The two strobes are high at every other time and are never low together.
- R4: The hold phase lasts `hold`+1 cycles. Both strobes are high during it, and the latch enable stays asserted.
- R5: `nand_cle` is 1 for the whole of a command cycle and `nand_ale` is 1 for the whole of an address cycle. Neither is asserted at any other time, and they are never both 1.
- R6: For command, address and write cycles, `nand_dq_oe` is 1 for the whole cycle and `nand_dq_out` carries the request data. Bits 15:8 of that data are 0 for command and address cycles and whenever the bus is 8 bits wide (width bit 0). For read cycles `nand_dq_oe` is 0.
- R7: A read captures `nand_dq_in` at the rising edge of `nand_re_n`. With an 8-bit bus, bits 15:8 of the captured value are 0. The value is on `rd_data` when `done` pulses.
- R8: `done` is a single-cycle pulse in the cycle right after the hold phase ends.
- R9: A configuration write (`cfg_wr`=1) loads all six configuration fields. After reset the values are: setup 1, active 0, hold 0, width 0, enable 1 and chip-enable bit 1. A cycle already in progress keeps the timing and width it latched at acceptance.
- R10: `nand_ce_n` is 0 exactly when the enable bit is 1 and the chip-enable bit is 0.
- R11: While the enable bit is 0, requests are not accepted. `busy` stays 0 and no pin leaves its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load all configuration fields |
| cfg_setup | input | 2 | Setup phase length in cycles |
| cfg_active | input | 3 | Active phase length minus one |
| cfg_hold | input | 3 | Hold phase length minus one |
| cfg_wide | input | 1 | 1 selects a 16-bit bus, 0 an 8-bit bus |
| cfg_en | input | 1 | Controller enable |
| cfg_ce_hi | input | 1 | 1 forces chip enable inactive, 0 asserts it |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 command, 1 address, 2 write, 3 read |
| req_data | input | 16 | Command, address or write data |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle end-of-cycle pulse |
| rd_data | output | 16 | Captured read data |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_dq_out | output | 16 | Data driven toward the flash |
| nand_dq_oe | output | 1 | Output enable for the data bus |
| nand_dq_in | input | 16 | Data from the flash |

## Verification
The bound checker watches the pin-level rules on every cycle. The two strobes are never low together, CLE and ALE are exclusive, and all pins are idle whenever `busy` is 0. `done` lasts one cycle and always follows the fall of `busy`. The chip enable stays inactive while the controller is disabled, and no request starts while it is disabled. The exact lengths of the setup, active and hold phases, the zero-length setup case, the byte masking, the read capture point and the rule that configuration is latched at acceptance can only be shown by the bench. It compares every pin against its queue-based model across a sweep of timing fields, request kinds and bus widths.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int SETUP_W  = 2;
  localparam int STROBE_W = 3;

  typedef logic [STROBE_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_WR   = 2'd2,
    K_RD   = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_HOLD
  } phase_e;

  typedef struct packed {
    logic [SETUP_W-1:0]  setup;
    logic [STROBE_W-1:0] active;
    logic [STROBE_W-1:0] hold;
    logic                wide;
  } timing_t;
endpackage

// File: rtl/nand_cfg_regs.sv
module nand_cfg_regs
  import nand_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [SETUP_W-1:0]  setup_in,
  input  logic [STROBE_W-1:0] active_in,
  input  logic [STROBE_W-1:0] hold_in,
  input  logic                wide_in,
  input  logic                en_in,
  input  logic                ce_hi_in,
  output timing_t             tim,
  output logic                en,
  output logic                ce_hi
);
  timing_t tim_d;
  logic    en_d, ce_hi_d;

  always_comb begin
    tim_d   = tim;
    en_d    = en;
    ce_hi_d = ce_hi;
    if (wr) begin
      tim_d.setup  = setup_in;
      tim_d.active = active_in;
      tim_d.hold   = hold_in;
      tim_d.wide   = wide_in;
      en_d         = en_in;
      ce_hi_d      = ce_hi_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim.setup  <= SETUP_W'(1);
      tim.active <= '0;
      tim.hold   <= '0;
      tim.wide   <= 1'b0;
      en         <= 1'b1;
      ce_hi      <= 1'b1;
    end else begin
      tim   <= tim_d;
      en    <= en_d;
      ce_hi <= ce_hi_d;
    end
  end
endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
  import nand_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  timing_t tim,
  output phase_e  phase,
  output logic    cap_edge,
  output logic    done
);
  phase_e ph_d;
  cnt_t   cnt_q, cnt_d;
  cnt_t   act_q, act_d;
  cnt_t   hold_q, hold_d;
  logic   done_d;

  always_comb begin
    ph_d   = phase;
    cnt_d  = cnt_q;
    act_d  = act_q;
    hold_d = hold_q;
    done_d = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          act_d  = tim.active;
          hold_d = tim.hold;
          if (tim.setup != '0) begin
            ph_d  = PH_SETUP;
            cnt_d = cnt_t'(tim.setup) - cnt_t'(1);
          end else begin
            ph_d  = PH_ACTIVE;
            cnt_d = tim.active;
          end
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          ph_d  = PH_ACTIVE;
          cnt_d = act_q;
        end else begin
          cnt_d = cnt_q - cnt_t'(1);
        end
      end
      PH_ACTIVE: begin
        if (cnt_q == '0) begin
          ph_d  = PH_HOLD;
          cnt_d = hold_q;
        end else begin
          cnt_d = cnt_q - cnt_t'(1);
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q - cnt_t'(1);
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  assign cap_edge = (phase == PH_ACTIVE) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt_q  <= '0;
      act_q  <= '0;
      hold_q <= '0;
      done   <= 1'b0;
    end else begin
      phase  <= ph_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      hold_q <= hold_d;
      done   <= done_d;
    end
  end
endmodule

// File: rtl/nand_pin_drive.sv
module nand_pin_drive
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  req_kind_e         kind,
  input  logic [DATA_W-1:0] data,
  input  logic              wide,
  input  phase_e            phase,
  input  logic              cap_edge,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              en,
  input  logic              ce_hi,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic              ce_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LO_W = DATA_W / 2;
  localparam int HI_W = DATA_W - LO_W;

  req_kind_e         kind_q, kind_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              wide_q, wide_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              narrow_in;
  logic              in_cycle;
  logic              strobing;

  assign narrow_in = (kind == K_CMD) || (kind == K_ADDR) || !wide;

  always_comb begin
    kind_d = kind_q;
    data_d = data_q;
    wide_d = wide_q;
    rd_d   = rd_q;
    if (start) begin
      kind_d = kind;
      wide_d = wide;
      data_d = narrow_in ? {{HI_W{1'b0}}, data[LO_W-1:0]} : data;
    end
    if (cap_edge && (kind_q == K_RD)) begin
      rd_d = wide_q ? dq_in : {{HI_W{1'b0}}, dq_in[LO_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_CMD;
      data_q <= '0;
      wide_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      kind_q <= kind_d;
      data_q <= data_d;
      wide_q <= wide_d;
      rd_q   <= rd_d;
    end
  end

  assign in_cycle = (phase != PH_IDLE);
  assign strobing = (phase == PH_ACTIVE);
  assign cle      = in_cycle && (kind_q == K_CMD);
  assign ale      = in_cycle && (kind_q == K_ADDR);
  assign we_n     = !(strobing && (kind_q != K_RD));
  assign re_n     = !(strobing && (kind_q == K_RD));
  assign dq_oe    = in_cycle && (kind_q != K_RD);
  assign dq_out   = dq_oe ? data_q : '0;
  assign ce_n     = !en || ce_hi;
  assign rd_data  = rd_q;
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [SETUP_W-1:0]  cfg_setup,
  input  logic [STROBE_W-1:0] cfg_active,
  input  logic [STROBE_W-1:0] cfg_hold,
  input  logic                cfg_wide,
  input  logic                cfg_en,
  input  logic                cfg_ce_hi,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic [DATA_W-1:0]   req_data,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   rd_data,
  output logic                nand_cle,
  output logic                nand_ale,
  output logic                nand_we_n,
  output logic                nand_re_n,
  output logic                nand_ce_n,
  output logic [DATA_W-1:0]   nand_dq_out,
  output logic                nand_dq_oe,
  input  logic [DATA_W-1:0]   nand_dq_in
);
  logic    rst_meta_n, rst_core_n;
  timing_t tim;
  logic    en_q, ce_hi_q;
  phase_e  phase;
  logic    cap_edge;
  logic    accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  nand_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_core_n), .wr(cfg_wr),
    .setup_in(cfg_setup), .active_in(cfg_active), .hold_in(cfg_hold),
    .wide_in(cfg_wide), .en_in(cfg_en), .ce_hi_in(cfg_ce_hi),
    .tim(tim), .en(en_q), .ce_hi(ce_hi_q)
  );

  assign accept = req_valid && en_q && (phase == PH_IDLE);
  assign busy   = (phase != PH_IDLE);

  nand_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_core_n), .start(accept), .tim(tim),
    .phase(phase), .cap_edge(cap_edge), .done(done)
  );

  nand_pin_drive #(.DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_core_n), .start(accept),
    .kind(req_kind_e'(req_kind)), .data(req_data), .wide(tim.wide),
    .phase(phase), .cap_edge(cap_edge), .dq_in(nand_dq_in),
    .en(en_q), .ce_hi(ce_hi_q),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .ce_n(nand_ce_n), .dq_out(nand_dq_out), .dq_oe(nand_dq_oe),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/nand_seq_checker.sv
module nand_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic req_valid,
  input logic en,
  input logic cle,
  input logic ale,
  input logic we_n,
  input logic re_n,
  input logic ce_n
);
  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  a_r5_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (we_n && re_n && !cle && !ale));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r10_ce_off_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> ce_n);

  a_r11_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !en && !busy) |=> !busy);
endmodule

bind nand_cycle_seq nand_seq_checker u_chk (
  .clk(clk), .rst_n(rst_core_n), .busy(busy), .done(done),
  .req_valid(req_valid), .en(en_q), .cle(nand_cle), .ale(nand_ale),
  .we_n(nand_we_n), .re_n(nand_re_n), .ce_n(nand_ce_n)
);

// File: tb/sim_nand_cycle_seq.sv
module sim_nand_cycle_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_setup = 2'd1;
  logic [2:0]  cfg_active = 3'd0;
  logic [2:0]  cfg_hold = 3'd0;
  logic        cfg_wide = 1'b0;
  logic        cfg_en = 1'b1;
  logic        cfg_ce_hi = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [15:0] req_data = 16'h0;
  logic        busy, done;
  logic [15:0] rd_data;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_ce_n, nand_dq_oe;
  logic [15:0] nand_dq_out;
  logic [15:0] nand_dq_in = 16'h0;

  always #4 clk = ~clk;

  nand_cycle_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_setup(cfg_setup),
    .cfg_active(cfg_active), .cfg_hold(cfg_hold), .cfg_wide(cfg_wide),
    .cfg_en(cfg_en), .cfg_ce_hi(cfg_ce_hi), .req_valid(req_valid),
    .req_kind(req_kind), .req_data(req_data), .busy(busy), .done(done),
    .rd_data(rd_data), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in)
  );

  typedef struct {
    bit busy, done, cle, ale, we_n, re_n, oe;
    logic [15:0] dq;
  } exp_t;

  exp_t  q[$];
  exp_t  cur;
  int    m_setup, m_active, m_hold;
  bit    m_wide, m_en, m_ce_hi;
  logic [15:0] m_rd;
  bit    m_is_rd;
  int    n_checks = 0, n_fail = 0;
  string scen = "R9 reset";
  bit    compare_on = 1'b0;

  function automatic exp_t idle_e();
    exp_t e;
    e.busy = 0; e.done = 0; e.cle = 0; e.ale = 0;
    e.we_n = 1; e.re_n = 1; e.oe = 0; e.dq = 16'h0;
    return e;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h t=%0t", tag, scen, what, act, expv, $time);
    end
  endtask

  // reference model: per-cycle expectations queued at acceptance
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = idle_e();
      m_setup = 1; m_active = 0; m_hold = 0;
      m_wide = 0; m_en = 1; m_ce_hi = 1; m_rd = 16'h0; m_is_rd = 0;
    end else begin
      bit acc;
      acc = req_valid && m_en && !cur.busy;
      cur = (q.size() > 0) ? q.pop_front() : idle_e();
      if (acc) begin
        exp_t e;
        bit narrow;
        narrow = (req_kind < 2) || !m_wide;
        e = idle_e();
        e.busy = 1;
        e.cle = (req_kind == 0);
        e.ale = (req_kind == 1);
        e.oe  = (req_kind != 3);
        e.dq  = narrow ? {8'h00, req_data[7:0]} : req_data;
        m_is_rd = (req_kind == 3);
        m_rd = m_wide ? nand_dq_in : {8'h00, nand_dq_in[7:0]};
        for (int i = 0; i < m_setup; i++) q.push_back(e);
        for (int i = 0; i <= m_active; i++) begin
          exp_t a;
          a = e;
          if (m_is_rd) a.re_n = 0; else a.we_n = 0;
          q.push_back(a);
        end
        for (int i = 0; i <= m_hold; i++) q.push_back(e);
        begin
          exp_t d;
          d = idle_e();
          d.done = 1;
          q.push_back(d);
        end
        cur = q.pop_front();
      end
      if (cfg_wr) begin
        m_setup = cfg_setup; m_active = cfg_active; m_hold = cfg_hold;
        m_wide = cfg_wide; m_en = cfg_en; m_ce_hi = cfg_ce_hi;
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      chk(busy == cur.busy, "R1", "busy", busy, cur.busy);
      chk(nand_cle == cur.cle, "R5", "cle", nand_cle, cur.cle);
      chk(nand_ale == cur.ale, "R5", "ale", nand_ale, cur.ale);
      chk(nand_we_n == cur.we_n, "R3", "we_n", nand_we_n, cur.we_n);
      chk(nand_re_n == cur.re_n, "R3", "re_n", nand_re_n, cur.re_n);
      chk(nand_dq_oe == cur.oe, "R6", "dq_oe", nand_dq_oe, cur.oe);
      if (cur.oe) chk(nand_dq_out == cur.dq, "R6", "dq_out", nand_dq_out, cur.dq);
      chk(done == cur.done, "R8", "done", done, cur.done);
      chk(nand_ce_n == (!m_en || m_ce_hi), "R10", "ce_n", nand_ce_n, (!m_en || m_ce_hi));
      if (cur.done && m_is_rd) chk(rd_data == m_rd, "R7", "rd_data", rd_data, m_rd);
    end
  end

  task automatic cfg(int s, int a, int h, bit w, bit en, bit cehi);
    @(negedge clk);
    cfg_setup = 2'(s); cfg_active = 3'(a); cfg_hold = 3'(h);
    cfg_wide = w; cfg_en = en; cfg_ce_hi = cehi; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (cur.busy || q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue(int kind, logic [15:0] d);
    @(negedge clk);
    req_valid = 1; req_kind = 2'(kind); req_data = d;
    @(negedge clk);
    req_valid = 0;
    wait_idle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(busy == 0, "R9", "busy after reset", busy, 0);
    chk(nand_ce_n == 1, "R9", "ce_n after reset", nand_ce_n, 1);
    chk(rd_data == 16'h0, "R9", "rd_data after reset", rd_data, 0);
    compare_on = 1;

    scen = "R9 default timing";
    issue(0, 16'hAB70);
    nand_dq_in = 16'h5AC3;
    issue(3, 16'h0);

    scen = "R2 R3 R4 sweep";
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 4; k++) begin
        cfg(s, (s * 3 + k) % 8, (k * 5 + s) % 8, k[0], 1, s[0]);
        nand_dq_in = 16'h1234 + 16'(s * 16 + k * 257);
        issue(k, 16'hC35A ^ 16'(s * 4 + k));
      end
    end

    scen = "R2 zero setup";
    cfg(0, 0, 0, 1, 1, 0);
    issue(1, 16'hFF11);
    issue(2, 16'hBEEF);

    scen = "R6 R7 narrow bus";
    cfg(2, 2, 1, 0, 1, 0);
    issue(2, 16'hBEEF);
    nand_dq_in = 16'hCAFE;
    issue(3, 16'h0);

    scen = "R1 request while busy";
    cfg(3, 7, 7, 1, 1, 0);
    @(negedge clk);
    req_valid = 1; req_kind = 2'd2; req_data = 16'h1111;
    @(negedge clk);
    req_kind = 2'd0; req_data = 16'h2222;
    repeat (5) @(negedge clk);
    req_valid = 0;
    wait_idle();

    scen = "R1 back to back";
    cfg(1, 1, 1, 1, 1, 0);
    @(negedge clk);
    req_valid = 1; req_kind = 2'd1; req_data = 16'h0042;
    repeat (14) @(negedge clk);
    req_valid = 0;
    wait_idle();

    scen = "R9 config during cycle";
    cfg(2, 4, 3, 1, 1, 0);
    @(negedge clk);
    req_valid = 1; req_kind = 2'd2; req_data = 16'h7E81;
    @(negedge clk);
    req_valid = 0;
    cfg_setup = 2'd0; cfg_active = 3'd0; cfg_hold = 3'd0; cfg_wide = 0; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
    wait_idle();
    issue(2, 16'h7E81);

    scen = "R11 disabled";
    cfg(1, 2, 2, 1, 0, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      req_valid = 1; req_kind = 2'(k); req_data = 16'h9999;
      @(negedge clk);
      req_valid = 0;
      @(negedge clk);
      chk(busy == 0, "R11", "busy while disabled", busy, 0);
      chk(nand_we_n && nand_re_n, "R11", "strobes while disabled", {nand_we_n, nand_re_n}, 3);
    end

    scen = "R10 chip enable";
    cfg(1, 0, 0, 0, 1, 1);
    repeat (2) @(negedge clk);
    cfg(1, 0, 0, 0, 1, 0);
    issue(0, 16'h00FF);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule